// File: doc/BRIEF.md
# General-Purpose Compare Timer

A 32-bit up-counting timer with one output-compare channel, reached through a simple memory-mapped register bus. The counter advances on a tick derived from one of several clock sources. Each source is modelled as an enable strobe in the single system clock domain. The selected tick passes through a programmable main divider. When the crystal source is selected, an optional 4-bit pre-divider can sit in front of the main divider. The timer is used as a time base: software reads the live count, programs a compare value, and takes an interrupt when the count reaches that value.

On a compare match, a sticky status flag is set. The flag drives the interrupt line through a mask bit, and software clears it by writing one to it. In free-run mode the counter runs straight through the match and wraps at its full width. In restart mode the counter falls back to zero on the tick after the match. A wait-mode input halts counting unless a control bit allows counting to continue while that input is asserted. Writing the control register with the enable bit clear returns the count and both divider states to zero.

Top module: `cmp_timer`

## Requirements
- R1: After reset, every register reads 0 and `irq_o` is low.
- R2: Registers sit at these byte offsets:
  - control at 0x00
  - divider at 0x04
  - status at 0x08
  - interrupt mask at 0x0C
  - compare at 0x10
  - count at 0x24

  Control keeps bits 0, 3, 8:6, 9 and 10, and its other bits read 0. The divider register keeps bits 15:0. The mask register keeps bit 0. Compare keeps all 32 bits. Any other offset reads 0. `rdata_o` shows the register selected by `addr_i` one clock after the address is presented. The count register is read-only, and writes to it have no effect.
- R3: The count advances only while control bit 0 is 1. While `wait_i` is high it also needs control bit 3 to be 1; otherwise the count holds.
- R4: Control bits 8:6 choose the count source:
  - 1 is every clock cycle.
  - 2 is `per_tick_i`.
  - 5 is the crystal path fed by `xtal_tick_i`.
  - Any other code gives no ticks.
- R5: Divider bits 11:0 hold value N. The count advances once per N+1 source ticks, so 0 gives one step per tick.
- R6: With control bit 10 set, the crystal path emits one tick per M+1 `xtal_tick_i` pulses, where M is divider bits 15:12. With control bit 10 clear, the crystal path passes `xtal_tick_i` straight through.
- R7: With control bit 9 set (free-run), the count keeps incrementing through a compare match and wraps from all-ones to 0.
- R8: With control bit 9 clear (restart), the count returns to 0 on the first step after it has equalled the compare value.
- R9: Status bit 0 is set on the same clock edge at which the count takes the compare value. A held count does not set the flag again.
- R10: Writing status with bit 0 = 1 clears the flag, and writing 0 leaves it unchanged. If a new match occurs on the same edge as a clear, the flag stays set.
- R11: `irq_o` is the flag ANDed with mask bit 0, registered, so it follows one clock later. Clearing the mask drops the interrupt but keeps the flag.
- R12: Writing control with bit 0 = 0 resets the count and both divider states to 0. The flag is not affected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe for the register at `addr_i` |
| addr_i | input | ADDR_W (6) | Byte offset of the register |
| wdata_i | input | DATA_W (32) | Write data |
| rdata_o | output | DATA_W (32) | Registered read data for the register addressed on the previous clock |
| per_tick_i | input | 1 | Peripheral-clock enable strobe |
| xtal_tick_i | input | 1 | Crystal-clock enable strobe |
| wait_i | input | 1 | Wait-mode indication |
| irq_o | output | 1 | Compare interrupt |

## Verification
Read data is due one clock after the address is driven. The compare flag changes on the same edge as the count step that reaches the compare value, and `irq_o` follows one edge later. The bench drives inputs on the falling edge and counts run edges exactly: `wait_i` is lowered for a known number of rising edges, then raised again to freeze the counter before any value is read. Every read or interrupt expectation is queued together with the cycle number in which it becomes due, and a falling-edge monitor compares the output only in that cycle.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
  // byte offsets on the register bus
  localparam int OFF_CTRL = 'h00;
  localparam int OFF_DIV  = 'h04;
  localparam int OFF_STAT = 'h08;
  localparam int OFF_MASK = 'h0C;
  localparam int OFF_CMP  = 'h10;
  localparam int OFF_CNT  = 'h24;

  // control field positions
  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_WAIT_BIT = 3;
  localparam int CTRL_SRC_LSB  = 6;
  localparam int CTRL_SRC_W    = 3;
  localparam int CTRL_FREE_BIT = 9;
  localparam int CTRL_XPRE_BIT = 10;

  // source codes
  localparam logic [CTRL_SRC_W-1:0] SRC_BUS  = 3'd1;
  localparam logic [CTRL_SRC_W-1:0] SRC_PER  = 3'd2;
  localparam logic [CTRL_SRC_W-1:0] SRC_XTAL = 3'd5;

  typedef struct packed {
    logic                  xpre_en;
    logic                  free_run;
    logic [CTRL_SRC_W-1:0] src;
    logic                  wait_run;
    logic                  enable;
  } ctrl_t;
endpackage

// File: rtl/cmp_timer_prescale.sv
module cmp_timer_prescale #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         run_i,
  input  logic         in_i,
  input  logic [W-1:0] div_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;

  // >= keeps the divider sane if the limit is lowered mid-count
  assign tick_o = run_i && in_i && (cnt_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (run_i && in_i)     cnt_q <= tick_o ? '0 : cnt_q + W'(1);
  end

  assert_div_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !clr_i) |=> (cnt_q == '0));
endmodule

// File: rtl/cmp_timer_core.sv
module cmp_timer_core #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              tick_i,
  input  logic              clr_i,
  input  logic              free_run_i,
  input  logic [DATA_W-1:0] cmp_i,
  input  logic              flag_clr_i,
  input  logic              ie_i,
  output logic [DATA_W-1:0] cnt_o,
  output logic              flag_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] cnt_q, cnt_nxt;
  logic              flag_q, irq_q, hit;

  always_comb begin
    cnt_nxt = (!free_run_i && cnt_q == cmp_i) ? '0 : cnt_q + DATA_W'(1);
    hit     = tick_i && !clr_i && (cnt_nxt == cmp_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (clr_i)       cnt_q <= '0;
      else if (tick_i) cnt_q <= cnt_nxt;
      // a new match beats a software clear
      if (hit)             flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
      irq_q <= flag_q & ie_i;
    end
  end

  assign cnt_o  = cnt_q;
  assign flag_o = flag_q;
  assign irq_o  = irq_q;

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !clr_i) |=> $stable(cnt_q));
  assert_restart_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !clr_i && !free_run_i && cnt_q == cmp_i) |=> (cnt_q == '0));
  assert_flag_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> (cnt_q == $past(cmp_i)));
  assert_mask_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ie_i |=> !irq_q);
endmodule

// File: rtl/cmp_timer_regs.sv
module cmp_timer_regs
  import cmp_timer_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int PDIV_W = 12,
  parameter int XDIV_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [DATA_W-1:0] cnt_i,
  input  logic              flag_i,
  output ctrl_t             ctrl_o,
  output logic [PDIV_W-1:0] pdiv_o,
  output logic [XDIV_W-1:0] xdiv_o,
  output logic              ie_o,
  output logic [DATA_W-1:0] cmp_o,
  output logic              ctrl_clr_o,
  output logic              flag_clr_o
);
  localparam int DIV_W = PDIV_W + XDIV_W;

  ctrl_t             ctrl_q;
  logic [DIV_W-1:0]  div_q;
  logic              ie_q;
  logic [DATA_W-1:0] cmp_q, rdata_q, rd_nxt;
  logic              sel_ctrl, sel_div, sel_stat, sel_mask, sel_cmp, sel_cnt;

  assign sel_ctrl = addr_i == ADDR_W'(OFF_CTRL);
  assign sel_div  = addr_i == ADDR_W'(OFF_DIV);
  assign sel_stat = addr_i == ADDR_W'(OFF_STAT);
  assign sel_mask = addr_i == ADDR_W'(OFF_MASK);
  assign sel_cmp  = addr_i == ADDR_W'(OFF_CMP);
  assign sel_cnt  = addr_i == ADDR_W'(OFF_CNT);

  always_comb begin
    rd_nxt = '0;
    if (sel_ctrl) begin
      rd_nxt[CTRL_EN_BIT]                      = ctrl_q.enable;
      rd_nxt[CTRL_WAIT_BIT]                    = ctrl_q.wait_run;
      rd_nxt[CTRL_SRC_LSB +: CTRL_SRC_W]       = ctrl_q.src;
      rd_nxt[CTRL_FREE_BIT]                    = ctrl_q.free_run;
      rd_nxt[CTRL_XPRE_BIT]                    = ctrl_q.xpre_en;
    end else if (sel_div)  rd_nxt[DIV_W-1:0] = div_q;
    else if (sel_stat)     rd_nxt[0]         = flag_i;
    else if (sel_mask)     rd_nxt[0]         = ie_q;
    else if (sel_cmp)      rd_nxt            = cmp_q;
    else if (sel_cnt)      rd_nxt            = cnt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      div_q   <= '0;
      ie_q    <= 1'b0;
      cmp_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (wr_i && sel_ctrl) begin
        ctrl_q.enable   <= wdata_i[CTRL_EN_BIT];
        ctrl_q.wait_run <= wdata_i[CTRL_WAIT_BIT];
        ctrl_q.src      <= wdata_i[CTRL_SRC_LSB +: CTRL_SRC_W];
        ctrl_q.free_run <= wdata_i[CTRL_FREE_BIT];
        ctrl_q.xpre_en  <= wdata_i[CTRL_XPRE_BIT];
      end
      if (wr_i && sel_div)  div_q <= wdata_i[DIV_W-1:0];
      if (wr_i && sel_mask) ie_q  <= wdata_i[0];
      if (wr_i && sel_cmp)  cmp_q <= wdata_i;
      rdata_q <= rd_nxt;
    end
  end

  assign ctrl_o     = ctrl_q;
  assign pdiv_o     = div_q[PDIV_W-1:0];
  assign xdiv_o     = div_q[DIV_W-1:PDIV_W];
  assign ie_o       = ie_q;
  assign cmp_o      = cmp_q;
  assign rdata_o    = rdata_q;
  assign ctrl_clr_o = wr_i && sel_ctrl && !wdata_i[CTRL_EN_BIT];
  assign flag_clr_o = wr_i && sel_stat && wdata_i[0];

  assert_disable_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_clr_o |=> !ctrl_o.enable);
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import cmp_timer_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int PDIV_W = 12,
  parameter int XDIV_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              per_tick_i,
  input  logic              xtal_tick_i,
  input  logic              wait_i,
  output logic              irq_o
);
  ctrl_t             ctrl;
  logic [PDIV_W-1:0] pdiv;
  logic [XDIV_W-1:0] xdiv;
  logic [DATA_W-1:0] cmp, cnt;
  logic              ie, ctrl_clr, flag_clr, flag;
  logic              run, xdiv_tick, xtal_path, src_tick, cnt_tick;

  assign run = ctrl.enable && (!wait_i || ctrl.wait_run);

  cmp_timer_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PDIV_W(PDIV_W), .XDIV_W(XDIV_W)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .cnt_i(cnt), .flag_i(flag),
    .ctrl_o(ctrl), .pdiv_o(pdiv), .xdiv_o(xdiv), .ie_o(ie), .cmp_o(cmp),
    .ctrl_clr_o(ctrl_clr), .flag_clr_o(flag_clr)
  );

  cmp_timer_prescale #(.W(XDIV_W)) u_xtal_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(ctrl_clr),
    .run_i(run && ctrl.xpre_en), .in_i(xtal_tick_i), .div_i(xdiv),
    .tick_o(xdiv_tick)
  );

  assign xtal_path = ctrl.xpre_en ? xdiv_tick : xtal_tick_i;

  always_comb begin
    case (ctrl.src)
      SRC_BUS:  src_tick = 1'b1;
      SRC_PER:  src_tick = per_tick_i;
      SRC_XTAL: src_tick = xtal_path;
      default:  src_tick = 1'b0;
    endcase
  end

  cmp_timer_prescale #(.W(PDIV_W)) u_main_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(ctrl_clr),
    .run_i(run), .in_i(src_tick), .div_i(pdiv), .tick_o(cnt_tick)
  );

  cmp_timer_core #(.DATA_W(DATA_W)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .tick_i(cnt_tick),
    .clr_i(ctrl_clr), .free_run_i(ctrl.free_run), .cmp_i(cmp),
    .flag_clr_i(flag_clr), .ie_i(ie), .cnt_o(cnt), .flag_o(flag),
    .irq_o(irq_o)
  );

  assert_src_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.src != SRC_BUS && ctrl.src != SRC_PER && ctrl.src != SRC_XTAL)
      |-> !cnt_tick);
endmodule

// File: tb/cmp_timer_bench.sv
`timescale 1ns/1ps
module cmp_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        per = 1'b0, xtal = 1'b0, wt = 1'b1;
  logic        irq;

  int cyc = 0, errors = 0, checks = 0;

  localparam logic [5:0] A_CTRL = 6'h00, A_DIV = 6'h04, A_STAT = 6'h08,
                         A_MASK = 6'h0C, A_CMP = 6'h10, A_CNT = 6'h24;
  localparam logic [31:0] C_BUS_FREE = 32'h241, C_BUS_RST = 32'h041,
                          C_WAIT = 32'h249, C_XTAL_DIV = 32'h741,
                          C_XTAL_DIR = 32'h341, C_PER = 32'h281,
                          C_NONE = 32'h2C1;

  cmp_timer u_cmp_timer (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .per_tick_i(per), .xtal_tick_i(xtal), .wait_i(wt),
    .irq_o(irq)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int          due;
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    item_t it;
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      it = sb.pop_front();
      check(it.tag, it.is_irq ? {31'b0, irq} : rdata, it.exp);
    end
  end

  task automatic wr_reg(logic [5:0] a, logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic expect_rd(logic [5:0] a, logic [31:0] e, string tag);
    addr = a;
    sb.push_back('{cyc + 1, 1'b0, e, tag});
    @(posedge clk); @(negedge clk);
  endtask

  task automatic expect_irq(logic e, string tag);
    sb.push_back('{cyc + 1, 1'b1, {31'b0, e}, tag});
  endtask

  task automatic run_cycles(int n);
    wt = 1'b0;
    repeat (n) @(posedge clk);
    @(negedge clk);
    wt = 1'b1;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", {31'b0, irq}, 32'h0);
    expect_rd(A_CTRL, 32'h0, "R1 ctrl");
    expect_rd(A_DIV,  32'h0, "R1 div");
    expect_rd(A_STAT, 32'h0, "R1 stat");
    expect_rd(A_MASK, 32'h0, "R1 mask");
    expect_rd(A_CMP,  32'h0, "R1 cmp");
    expect_rd(A_CNT,  32'h0, "R1 cnt");

    // R2 map and field widths
    wr_reg(A_CMP, 32'hDEADBEEF);
    expect_rd(A_CMP, 32'hDEADBEEF, "R2 cmp");
    wr_reg(A_DIV, 32'hFFFFFFFF);
    expect_rd(A_DIV, 32'h0000FFFF, "R2 div");
    wr_reg(A_MASK, 32'hFFFFFFFF);
    expect_rd(A_MASK, 32'h1, "R2 mask");
    wr_reg(A_CTRL, 32'hFFFFFFFE);
    expect_rd(A_CTRL, 32'h7C8, "R2 ctrl");
    expect_rd(6'h14, 32'h0, "R2 hole");
    wr_reg(A_MASK, 0);
    wr_reg(A_CMP, 32'hFFFF0000);
    wr_reg(A_DIV, 0);

    // R3 enable and wait gating, bus source
    wr_reg(A_CTRL, C_BUS_FREE);
    repeat (4) begin @(posedge clk); @(negedge clk); end
    expect_rd(A_CNT, 32'h0, "R3 held by wait");
    run_cycles(7);
    expect_rd(A_CNT, 32'd7, "R3 bus count");
    wr_reg(A_CTRL, 32'h0);
    expect_rd(A_CNT, 32'h0, "R12 clear on disable");
    wr_reg(A_CTRL, C_WAIT);
    repeat (5) @(posedge clk);
    @(negedge clk);
    wr_reg(A_CTRL, C_BUS_FREE);
    expect_rd(A_CNT, 32'd6, "R3 wait enable");

    // R5 main divider
    wr_reg(A_CTRL, 0);
    wr_reg(A_DIV, 3);
    wr_reg(A_CTRL, C_BUS_FREE);
    run_cycles(10);
    expect_rd(A_CNT, 32'd2, "R5 div by 4");
    run_cycles(2);
    expect_rd(A_CNT, 32'd3, "R5 divider state kept");
    wr_reg(A_CTRL, 0);
    run_cycles(2);
    wr_reg(A_DIV, 0);

    // R4 sources
    wr_reg(A_CTRL, C_PER);
    run_cycles(5);
    expect_rd(A_CNT, 32'd0, "R4 per idle");
    per = 1'b1;
    run_cycles(4);
    expect_rd(A_CNT, 32'd4, "R4 per strobe");
    wr_reg(A_CTRL, 0);
    xtal = 1'b1;
    wr_reg(A_CTRL, C_NONE);
    run_cycles(4);
    expect_rd(A_CNT, 32'd0, "R4 unused code");
    per = 1'b0;

    // R6 crystal path
    wr_reg(A_CTRL, 0);
    wr_reg(A_DIV, 32'h7000);
    wr_reg(A_CTRL, C_XTAL_DIV);
    run_cycles(16);
    expect_rd(A_CNT, 32'd2, "R6 crystal div by 8");
    wr_reg(A_CTRL, 0);
    wr_reg(A_CTRL, C_XTAL_DIR);
    run_cycles(3);
    expect_rd(A_CNT, 32'd3, "R6 crystal direct");
    xtal = 1'b0;
    wr_reg(A_CTRL, 0);
    wr_reg(A_DIV, 0);

    // R9 R11 R7 compare in free-run
    wr_reg(A_CMP, 5);
    wr_reg(A_MASK, 1);
    wr_reg(A_CTRL, C_BUS_FREE);
    run_cycles(4);
    expect_rd(A_STAT, 32'h0, "R9 no flag before match");
    run_cycles(1);
    check("R11 irq lags flag", {31'b0, irq}, 32'h0);
    expect_irq(1'b1, "R11 irq asserted");
    expect_rd(A_STAT, 32'h1, "R9 flag at match");
    run_cycles(3);
    expect_rd(A_CNT, 32'd8, "R7 free-run past match");
    expect_rd(A_STAT, 32'h1, "R9 flag sticky");
    wr_reg(A_MASK, 0);
    check("R11 irq before mask lands", {31'b0, irq}, 32'h1);
    expect_irq(1'b0, "R11 masked");
    expect_rd(A_STAT, 32'h1, "R11 mask keeps flag");
    wr_reg(A_STAT, 0);
    expect_rd(A_STAT, 32'h1, "R10 write zero ignored");
    wr_reg(A_STAT, 1);
    expect_rd(A_STAT, 32'h0, "R10 write one clears");

    // R8 restart mode, R9 once per value
    wr_reg(A_CTRL, 0);
    wr_reg(A_CMP, 3);
    wr_reg(A_CTRL, C_BUS_RST);
    run_cycles(3);
    expect_rd(A_CNT, 32'd3, "R8 reached compare");
    expect_rd(A_STAT, 32'h1, "R9 restart flag");
    wr_reg(A_STAT, 1);
    repeat (4) begin @(posedge clk); @(negedge clk); end
    expect_rd(A_STAT, 32'h0, "R9 held count no reset of flag");
    run_cycles(1);
    expect_rd(A_CNT, 32'd0, "R8 reload to zero");
    expect_rd(A_STAT, 32'h0, "R9 no flag on reload");
    run_cycles(3);
    expect_rd(A_CNT, 32'd3, "R8 second period");
    expect_rd(A_STAT, 32'h1, "R9 flag again");

    // R2 count read-only, R12 clear keeps flag
    wr_reg(A_CNT, 32'h1234);
    expect_rd(A_CNT, 32'd3, "R2 count read-only");
    wr_reg(A_CTRL, 32'h040);
    expect_rd(A_CNT, 32'd0, "R12 count cleared");
    expect_rd(A_STAT, 32'h1, "R12 flag kept");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule